// File: doc/BRIEF.md
# CPU-loaded packet transmit buffer

This block sits between a host processor bus and a downstream frame builder. Software pushes an outgoing frame into a 64-entry queue of 32-bit words through a small register window. On the far side the queue drains as a word stream, and each word carries three markers: the first word of a frame, the last word of a frame, and how many bytes of that word are valid. A configuration bit asks the downstream framer to append a frame check sequence. The block only carries that bit to its output and computes no checksum.

Software polls a status word that has two flags. One says a single word fits. The other says a burst of eight words fits, so eight writes can follow without polling again. Before writing the closing word of a frame, software arms an end marker and a padding count in the control register. These attach to the next word written and then disarm. There are two data ports. The plain port never stalls. A write to it while the queue is full raises a sticky abort flag and throws away the rest of that frame. The stalling port holds the bus with a wait request until a slot frees up.

Register reads have no side effects, and the read data is a combinational mux of the addressed register.

Top module: `pkt_txbuf`

## Requirements
- R1: After reset the status register reads 0x3 (ready and block-ready set, abort clear), configuration and control read 0, `out_valid` is low and `out_fcs_en` is low.
- R2: Register map on `host_addr`. Status is at 0x204 (bit0 word-ready, bit1 block-ready, bit2 abort). Configuration is at 0x20C (bit0 FCS enable, mirrored on `out_fcs_en` from the cycle after the write). Control is at 0x21C (bit0 end marker, bits 5:4 padding byte count). The plain data port is at 0x220 and the stalling data port is at 0x224.
- R3: Word-ready is 1 exactly when at least one of the DEPTH (64) entries is free. Block-ready is 1 exactly when at least BLOCK (8) entries are free.
- R4: The armed end marker and padding count attach to the next data word the block accepts on either port, and the control register then reads 0.
- R5: Accepted words leave in write order, one per cycle while `out_ready` is high. `out_sop` marks the first word of each frame. `out_eop` marks a word written with the end marker armed. `out_bytes` is 4 on other words and 4 minus the padding count on an end word. The outputs hold steady while `out_valid` is high and `out_ready` is low.
- R6: A write to the plain data port while all 64 entries are occupied stores nothing and sets the abort flag.
- R7: After an abort, data words are dropped up to and including the next word written with the end marker armed. The following accepted word is emitted with `out_sop` set.
- R8: The abort flag stays set until the status register is written with bit2 = 1. A status write with bit2 = 0 leaves it set.
- R9: A write to the stalling port while the queue is full holds `host_waitreq` high and stores nothing. The word is stored once a slot frees, and the abort flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 12 | Register byte address |
| host_write | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the addressed register |
| host_waitreq | output | 1 | Bus stall for stalling-port writes while full |
| out_valid | output | 1 | Stream word present |
| out_ready | input | 1 | Downstream takes the word this cycle |
| out_data | output | 32 | Stream word |
| out_sop | output | 1 | First word of a frame |
| out_eop | output | 1 | Last word of a frame |
| out_bytes | output | 3 | Valid bytes in the word (1..4) |
| out_fcs_en | output | 1 | FCS append request to the framer |

## Verification
The bench fills the queue exactly to its 57th and 64th word to catch the two ready flags changing one entry too early or too late. An off-by-one there would tell software that space exists when the next write will overrun. It then overruns the plain port and checks three things: the dropped word never appears, the tail of the aborted frame is swallowed through its end word, and the next frame restarts with a start marker. A design that resumed storing too early would leak orphan words downstream. The abort flag is hit with a status write that has bit2 clear, to show only a bit2 = 1 write clears it. A stalled write on the waiting port is released by draining. A wrong design would either lose that word or raise a spurious abort.

// File: rtl/pkt_txbuf_pkg.sv
package pkt_txbuf_pkg;

    localparam int ADDR_W = 12;
    localparam int WORD_W = 32;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_CONFIG = 12'h20C;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h21C;
    localparam logic [ADDR_W-1:0] OFS_DPLAIN = 12'h220;
    localparam logic [ADDR_W-1:0] OFS_DSTALL = 12'h224;

    // status bit positions
    localparam int ST_READY = 0;
    localparam int ST_BLOCK = 1;
    localparam int ST_ABORT = 2;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              sop;
        logic              eop;
        logic [1:0]        pad;
    } txbuf_entry_t;

    function automatic logic [2:0] valid_bytes(input txbuf_entry_t e);
        return e.eop ? (3'd4 - {1'b0, e.pad}) : 3'd4;
    endfunction

endpackage

// File: rtl/pkt_txbuf_fifo.sv
// Word queue; DEPTH must be a power of two.
module pkt_txbuf_fifo
    import pkt_txbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int BLOCK = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  txbuf_entry_t push_entry,
    input  logic         pop,
    output txbuf_entry_t head,
    output logic         empty,
    output logic         full,
    output logic         room_block
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    txbuf_entry_t   mem [DEPTH];
    logic [CW-1:0]  wptr, rptr, level;

    assign level      = wptr - rptr;
    assign full       = (level == CW'(DEPTH));
    assign empty      = (level == '0);
    assign room_block = ((CW'(DEPTH) - level) >= CW'(BLOCK));
    assign head       = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr[AW-1:0]] <= push_entry;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (rst) level <= CW'(DEPTH));

endmodule

// File: rtl/pkt_txbuf_regs.sv
// Host register window: decodes writes, builds queue entries, tracks abort.
module pkt_txbuf_regs
    import pkt_txbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_write,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_waitreq,
    input  logic              q_full,
    input  logic              q_room_block,
    output logic              push,
    output txbuf_entry_t      push_entry,
    output logic              fcs_en
);
    logic       eop_arm, abort_q, discard, sop_pending;
    logic [1:0] pad_arm;
    logic       wr_plain, wr_stall, wr_status, wr_cfg, wr_ctrl;
    logic       word_taken, overrun;

    assign wr_plain  = host_write && (host_addr == OFS_DPLAIN);
    assign wr_stall  = host_write && (host_addr == OFS_DSTALL);
    assign wr_status = host_write && (host_addr == OFS_STATUS);
    assign wr_cfg    = host_write && (host_addr == OFS_CONFIG);
    assign wr_ctrl   = host_write && (host_addr == OFS_CTRL);

    assign host_waitreq = wr_stall && q_full;
    assign word_taken   = wr_plain || (wr_stall && !q_full);
    assign overrun      = wr_plain && q_full;
    assign push         = word_taken && !overrun && !discard;

    always_comb begin
        push_entry      = '0;
        push_entry.data = host_wdata;
        push_entry.sop  = sop_pending;
        push_entry.eop  = eop_arm;
        push_entry.pad  = eop_arm ? pad_arm : 2'd0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fcs_en      <= 1'b0;
            eop_arm     <= 1'b0;
            pad_arm     <= 2'd0;
            abort_q     <= 1'b0;
            discard     <= 1'b0;
            sop_pending <= 1'b1;
        end else begin
            if (wr_cfg) fcs_en <= host_wdata[0];
            if (wr_ctrl) begin
                eop_arm <= host_wdata[0];
                pad_arm <= host_wdata[5:4];
            end
            if (wr_status && host_wdata[ST_ABORT]) abort_q <= 1'b0;
            if (word_taken) begin
                eop_arm <= 1'b0;
                pad_arm <= 2'd0;
                if (overrun) begin
                    abort_q     <= 1'b1;
                    discard     <= !eop_arm;
                    sop_pending <= 1'b1;
                end else if (discard) begin
                    if (eop_arm) discard <= 1'b0;
                end else begin
                    sop_pending <= eop_arm;
                end
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_STATUS: begin
                host_rdata[ST_READY] = !q_full;
                host_rdata[ST_BLOCK] = q_room_block;
                host_rdata[ST_ABORT] = abort_q;
            end
            OFS_CONFIG: host_rdata[0] = fcs_en;
            OFS_CTRL: begin
                host_rdata[0]   = eop_arm;
                host_rdata[5:4] = pad_arm;
            end
            default: host_rdata = '0;
        endcase
    end

    // R8
    abort_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_q && !(wr_status && host_wdata[ST_ABORT])) |=> abort_q);
    // R6
    abort_on_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_plain && q_full) |=> abort_q);
    // R9
    stall_only_full_chk: assert property (@(posedge clk) disable iff (rst)
        host_waitreq |-> (q_full && !push));
    // R4
    arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (word_taken && !wr_ctrl) |=> (!eop_arm && pad_arm == 2'd0));

endmodule

// File: rtl/pkt_txbuf.sv
module pkt_txbuf
    import pkt_txbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int BLOCK = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_write,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_waitreq,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic [2:0]        out_bytes,
    output logic              out_fcs_en
);
    txbuf_entry_t push_entry, head;
    logic         push, q_empty, q_full, q_room_block;

    pkt_txbuf_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .host_addr    (host_addr),
        .host_write   (host_write),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .host_waitreq (host_waitreq),
        .q_full       (q_full),
        .q_room_block (q_room_block),
        .push         (push),
        .push_entry   (push_entry),
        .fcs_en       (out_fcs_en)
    );

    pkt_txbuf_fifo #(.DEPTH(DEPTH), .BLOCK(BLOCK)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_entry (push_entry),
        .pop        (out_valid && out_ready),
        .head       (head),
        .empty      (q_empty),
        .full       (q_full),
        .room_block (q_room_block)
    );

    assign out_valid = !q_empty;
    assign out_data  = head.data;
    assign out_sop   = head.sop;
    assign out_eop   = head.eop;
    assign out_bytes = valid_bytes(head);

    // R5
    bytes_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_bytes != 3'd0 && out_bytes <= 3'd4));
    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)));

endmodule

// File: tb/pkt_txbuf_bench.sv
module pkt_txbuf_bench;
    import pkt_txbuf_pkg::*;

    typedef struct packed {
        logic [31:0] d;
        logic        s;
        logic        e;
        logic [2:0]  b;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] host_addr = '0;
    logic        host_write = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_waitreq;
    logic        out_valid, out_ready, out_sop, out_eop, out_fcs_en;
    logic [31:0] out_data;
    logic [2:0]  out_bytes;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    pkt_txbuf u_pkt_txbuf (
        .clk (clk), .rst (rst),
        .host_addr (host_addr), .host_write (host_write), .host_wdata (host_wdata),
        .host_rdata (host_rdata), .host_waitreq (host_waitreq),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_sop (out_sop), .out_eop (out_eop), .out_bytes (out_bytes),
        .out_fcs_en (out_fcs_en)
    );

    initial out_ready = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_write = 1'b1;
        #9;
        while (host_waitreq) begin
            @(negedge clk);
            #9;
        end
        @(negedge clk);
        host_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr  = a;
        host_write = 1'b0;
        #5 d = host_rdata;
    endtask

    // Data word write; pushes the expected stream item when it will be kept.
    task automatic send(input logic [11:0] port, input logic [31:0] d, input bit keep,
                        input bit s, input bit e, input logic [1:0] pad);
        exp_t x;
        if (keep) begin
            x.d = d; x.s = s; x.e = e;
            x.b = e ? (3'd4 - {1'b0, pad}) : 3'd4;
            exp_q.push_back(x);
        end
        bus_wr(port, d);
    endtask

    task automatic drain();
        @(negedge clk);
        out_ready = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        out_ready = 1'b0;
    endtask

    // Monitor: samples 1 ns before each rising edge.
    initial begin
        exp_t x;
        forever begin
            @(negedge clk);
            #9;
            if (!rst && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R5: unexpected word actual %h expected none", out_data);
                end else begin
                    x = exp_q.pop_front();
                    chk("R5 data", out_data, x.d);
                    chk("R5 sop/R7", {31'd0, out_sop}, {31'd0, x.s});
                    chk("R5 eop", {31'd0, out_eop}, {31'd0, x.e});
                    chk("R5 bytes", {29'd0, out_bytes}, {29'd0, x.b});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R5: watchdog expired, actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_rd(OFS_STATUS, r); chk("R1 status", r, 32'h3);
        bus_rd(OFS_CONFIG, r); chk("R1 config", r, 32'h0);
        bus_rd(OFS_CTRL, r);   chk("R1 control", r, 32'h0);
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
        chk("R1 fcs", {31'd0, out_fcs_en}, 32'd0);

        // R2 configuration bit
        bus_wr(OFS_CONFIG, 32'h1);
        chk("R2 fcs out", {31'd0, out_fcs_en}, 32'd1);
        bus_rd(OFS_CONFIG, r); chk("R2 config read", r, 32'h1);

        // R4/R5 short frame, padding 2
        out_ready = 1'b1;
        send(OFS_DPLAIN, 32'hA0000001, 1, 1, 0, 0);
        send(OFS_DPLAIN, 32'hA0000002, 1, 0, 0, 0);
        bus_wr(OFS_CTRL, 32'h21);
        bus_rd(OFS_CTRL, r); chk("R4 control armed", r, 32'h21);
        send(OFS_DPLAIN, 32'hA0000003, 1, 0, 1, 2'd2);
        bus_rd(OFS_CTRL, r); chk("R4 control cleared", r, 32'h0);
        drain();

        // R3 fill levels, then R6 overrun
        for (int i = 0; i < 56; i++) send(OFS_DPLAIN, 32'hB0000000 + i, 1, i == 0, 0, 0);
        bus_rd(OFS_STATUS, r); chk("R3 eight free", r, 32'h3);
        send(OFS_DPLAIN, 32'hB0000038, 1, 0, 0, 0);
        bus_rd(OFS_STATUS, r); chk("R3 seven free", r, 32'h1);
        for (int i = 57; i < 64; i++) send(OFS_DPLAIN, 32'hB0000000 + i, 1, 0, 0, 0);
        bus_rd(OFS_STATUS, r); chk("R3 full", r, 32'h0);
        send(OFS_DPLAIN, 32'hDEAD0000, 0, 0, 0, 0);
        bus_rd(OFS_STATUS, r); chk("R6 abort set", r, 32'h4);
        drain();

        // R8 write with bit2 clear leaves abort set
        bus_wr(OFS_STATUS, 32'h3);
        bus_rd(OFS_STATUS, r); chk("R8 abort kept", r, 32'h7);

        // R7 rest of aborted frame is swallowed
        send(OFS_DPLAIN, 32'hDEAD0001, 0, 0, 0, 0);
        send(OFS_DPLAIN, 32'hDEAD0002, 0, 0, 0, 0);
        bus_wr(OFS_CTRL, 32'h01);
        send(OFS_DPLAIN, 32'hDEAD0003, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk("R7 nothing queued", {31'd0, out_valid}, 32'd0);
        send(OFS_DPLAIN, 32'hC0000001, 1, 1, 0, 0);
        bus_wr(OFS_CTRL, 32'h01);
        send(OFS_DPLAIN, 32'hC0000002, 1, 0, 1, 2'd0);
        drain();
        bus_wr(OFS_STATUS, 32'h4);
        bus_rd(OFS_STATUS, r); chk("R8 abort cleared", r, 32'h3);

        // R9 stalling port
        for (int i = 0; i < 64; i++) send(OFS_DSTALL, 32'hE0000000 + i, 1, i == 0, 0, 0);
        bus_wr(OFS_CTRL, 32'h11);
        begin
            exp_t x;
            x.d = 32'hE0000040; x.s = 1'b0; x.e = 1'b1; x.b = 3'd3;
            exp_q.push_back(x);
        end
        fork
            bus_wr(OFS_DSTALL, 32'hE0000040);
            begin
                repeat (3) @(negedge clk);
                #5 chk("R9 waitreq high", {31'd0, host_waitreq}, 32'd1);
                out_ready = 1'b1;
            end
        join
        drain();
        bus_rd(OFS_STATUS, r); chk("R9 no abort", r, 32'h3);
        chk("R5 all words seen", exp_q.size(), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule